// File: doc/BRIEF.md
# Byte-Serial 2x2 Systolic Matrix Multiplier

This block multiplies two 2x2 matrices of signed 8-bit numbers. The host streams in eight bytes. The first four bytes form the left operand W and the next four form the right operand X. Each operand arrives row by row. The block computes C = W x X on a 2x2 grid of multiply-accumulate cells. The operands are fed into the grid with a skew, so that each product term reaches its cell in the correct cycle. The four 16-bit results are then streamed back out as bytes.

Two mode inputs are captured together with the last operand byte. The first makes the grid use the transpose of X without any extra pass. The second clamps negative results to zero (ReLU). A done flag and the 2-bit controller state are visible on pins.

Both data directions use valid/ready. A byte moves on any rising edge where its valid and ready are both high. The block raises `in_ready` only while it is loading. A sender may drop `in_valid` at any time, and loading resumes where it stopped. On the output side, `out_valid` stays high for the whole unload. A low `out_ready` stalls the stream: the byte on `out_data` is held, and no byte is lost or repeated. With `out_ready` held high, the unload takes 8 clocks.

Top module: `sysmm_core`

## Requirements
- R1: While `rst_n` is low (active low), `state` is 00, `done` is 0, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` is high only in state 00 (load). A byte is taken on each edge where `in_valid` and `in_ready` are both high. The eight taken bytes are W00, W01, W10, W11, X00, X01, X10, X11. The edge that takes the eighth byte moves `state` to 01.
- R3: A byte offered while `in_valid` is low, or while `in_ready` is low, is not stored. The load count holds across such cycles.
- R4: Each result is the low 16 bits of the exact signed sum of W[i][k]*X[k][j] over k. `state` stays at 01 for exactly 4 cycles, then spends one cycle at 11.
- R5: If `xpose_en` is high on the edge that takes the eighth byte, the result is W x transpose(X). The value of `xpose_en` at any other time has no effect.
- R6: If `relu_en` is high on the edge that takes the eighth byte, any result with bit 15 set is output as 0. The value of `relu_en` at any other time has no effect.
- R7: In state 10, `out_valid` is high and the result bytes appear in this order: C00 high, C00 low, C01 high, C01 low, C10 high, C10 low, C11 high, C11 low. The stream advances one byte on each edge where `out_valid` and `out_ready` are both high.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold on the next cycle.
- R9: The edge that transfers the eighth output byte returns `state` to 00, with `done` low and `in_ready` high.
- R10: `done` is high exactly in states 11 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 8 | Operand byte, signed |
| in_valid | input | 1 | Operand byte offered |
| in_ready | output | 1 | Block accepts operand bytes (load state) |
| xpose_en | input | 1 | Use transpose of the second operand |
| relu_en | input | 1 | Clamp negative results to zero |
| out_data | output | 8 | Result byte |
| out_valid | output | 1 | Result byte offered |
| out_ready | input | 1 | Receiver takes the result byte |
| done | output | 1 | Results available |
| state | output | 2 | Controller state: 00 load, 01 compute, 10 send, 11 ready |

## Verification
Faults show up at the ports in different ways, and at different times:

- **Load count.** A load count that advances on an untaken byte shows up as `state` leaving 00 one byte early. It also shows as every later result byte being computed from shifted operands.
- **Compute length.** A wrong compute length is seen within a few cycles, because `state` and `done` are compared against a reference model on every clock.
- **Skew or accumulator clear.** A bad skew or a missing accumulator clear only corrupts `out_data`. It appears at the first send-phase byte, about six cycles after the last load byte.
- **Mode capture.** A mode latched on the wrong edge is exposed by toggling both mode inputs during compute.

// File: rtl/sysmm_pkg.sv
package sysmm_pkg;
  typedef enum logic [1:0] {
    ST_LOAD  = 2'b00,
    ST_MAC   = 2'b01,
    ST_SEND  = 2'b10,
    ST_READY = 2'b11
  } mm_state_e;
endpackage

// File: rtl/sysmm_loader.sv
module sysmm_loader #(
  parameter int DW = 8,
  parameter int N  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        take,
  input  logic [DW-1:0]               din,
  output logic                        last,
  output logic [N*N-1:0][DW-1:0]      wmat,
  output logic [N*N-1:0][DW-1:0]      xmat
);
  localparam int TOT = 2 * N * N;
  localparam int CW  = $clog2(TOT);

  logic [CW-1:0]           cnt_q;
  logic [TOT-1:0][DW-1:0]  mem_q;

  assign last = take && (cnt_q == CW'(TOT - 1));
  assign wmat = mem_q[N*N-1:0];
  assign xmat = mem_q[TOT-1:N*N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mem_q <= '0;
    end else if (take) begin
      mem_q[cnt_q] <= din;
      cnt_q        <= last ? '0 : cnt_q + 1'b1;
    end
  end

  // R3
  load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(cnt_q) && $stable(mem_q)));
endmodule

// File: rtl/sysmm_cell.sv
module sysmm_cell #(
  parameter int DW = 8,
  parameter int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  output logic [DW-1:0] a_out,
  output logic [DW-1:0] b_out,
  output logic [AW-1:0] acc
);
  logic signed [2*DW-1:0] prod;
  assign prod = $signed(a_in) * $signed(b_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_out <= '0;
      b_out <= '0;
      acc   <= '0;
    end else if (clr) begin
      a_out <= '0;
      b_out <= '0;
      acc   <= '0;
    end else if (en) begin
      a_out <= a_in;
      b_out <= b_in;
      acc   <= acc + AW'(prod);
    end
  end
endmodule

// File: rtl/sysmm_serial.sv
module sysmm_serial #(
  parameter int DW = 8,
  parameter int N  = 2,
  parameter int AW = 2 * DW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    active,
  input  logic                    relu,
  input  logic [N*N-1:0][AW-1:0]  res,
  input  logic                    rdy,
  output logic [DW-1:0]           dout,
  output logic                    vld,
  output logic                    last
);
  localparam int BPE = AW / DW;
  localparam int NB  = N * N * BPE;
  localparam int IW  = $clog2(NB);

  logic [IW-1:0] idx_q;
  logic [AW-1:0] elem_v;
  logic          fire;
  logic          hi_part;

  assign vld     = active;
  assign fire    = active && rdy;
  assign last    = fire && (idx_q == IW'(NB - 1));
  assign hi_part = (int'(idx_q) % BPE) == 0;

  always_comb begin
    elem_v = res[int'(idx_q) / BPE];
    if (relu && elem_v[AW-1]) elem_v = '0;
    dout = elem_v[(BPE - 1 - int'(idx_q) % BPE) * DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx_q <= '0;
    else if (fire) idx_q <= last ? '0 : idx_q + 1'b1;
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !rdy) |=> (vld && $stable(dout)));
  // R6
  relu_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && relu && hi_part) |-> !dout[DW-1]);
endmodule

// File: rtl/sysmm_core.sv
module sysmm_core #(
  parameter int DW = 8,
  parameter int N  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          xpose_en,
  input  logic          relu_en,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          done,
  output logic [1:0]    state
);
  import sysmm_pkg::*;

  localparam int AW = 2 * DW;
  localparam int NC = 3 * N - 2;
  localparam int TW = $clog2(NC + 1);

  mm_state_e                 state_q;
  logic [TW-1:0]             tcnt_q;
  logic                      xp_q, rl_q;
  logic                      take, load_last, ser_last, mac_en;
  logic [N*N-1:0][DW-1:0]    wmat, xmat;
  logic [N*N-1:0][AW-1:0]    res;
  logic [DW-1:0]             ah [N][N+1];
  logic [DW-1:0]             bv [N+1][N];

  assign in_ready = (state_q == ST_LOAD);
  assign take     = in_valid && in_ready;
  assign mac_en   = (state_q == ST_MAC);
  assign done     = (state_q == ST_READY) || (state_q == ST_SEND);
  assign state    = state_q;

  sysmm_loader #(.DW(DW), .N(N)) u_load (
    .clk(clk), .rst_n(rst_n), .take(take), .din(in_data),
    .last(load_last), .wmat(wmat), .xmat(xmat)
  );

  for (genvar i = 0; i < N; i++) begin : g_edge
    logic [DW-1:0] a_v, b_v;
    always_comb begin
      int k;
      k   = int'(tcnt_q) - i;
      a_v = '0;
      b_v = '0;
      if (k >= 0 && k < N) begin
        a_v = wmat[i*N + k];
        b_v = xp_q ? xmat[i*N + k] : xmat[k*N + i];
      end
    end
    assign ah[i][0] = a_v;
    assign bv[0][i] = b_v;
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      sysmm_cell #(.DW(DW), .AW(AW)) u_cell (
        .clk(clk), .rst_n(rst_n), .clr(load_last), .en(mac_en),
        .a_in(ah[i][j]), .b_in(bv[i][j]),
        .a_out(ah[i][j+1]), .b_out(bv[i+1][j]),
        .acc(res[i*N + j])
      );
    end
  end

  sysmm_serial #(.DW(DW), .N(N), .AW(AW)) u_ser (
    .clk(clk), .rst_n(rst_n), .active(state_q == ST_SEND), .relu(rl_q),
    .res(res), .rdy(out_ready), .dout(out_data), .vld(out_valid),
    .last(ser_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOAD;
      tcnt_q  <= '0;
      xp_q    <= 1'b0;
      rl_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_LOAD: if (load_last) begin
          state_q <= ST_MAC;
          tcnt_q  <= '0;
          xp_q    <= xpose_en;
          rl_q    <= relu_en;
        end
        ST_MAC: begin
          if (tcnt_q == TW'(NC - 1)) state_q <= ST_READY;
          else                       tcnt_q  <= tcnt_q + 1'b1;
        end
        ST_READY: state_q <= ST_SEND;
        ST_SEND:  if (ser_last) state_q <= ST_LOAD;
        default:  state_q <= ST_LOAD;
      endcase
    end
  end

  // R4
  mac_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MAC) |=> (state_q == ST_MAC || state_q == ST_READY));
  // R2
  ready_only_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!out_valid && !done));
  // R9
  back_to_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_last |=> (in_ready && !done));
  // R10
  ready_then_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READY) |=> (out_valid && done));
endmodule

// File: tb/sysmm_core_bench.sv
module sysmm_core_bench;
  localparam int CLK_P = 10;
  localparam int WDOG  = 50000;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0, xpose_en = 1'b0, relu_en = 1'b0, out_ready = 1'b0;
  logic       in_ready, out_valid, done;
  logic [7:0] out_data;
  logic [1:0] state;

  int n_run = 0, n_fail = 0, cyc = 0;

  sysmm_core u_sysmm_core (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .xpose_en(xpose_en), .relu_en(relu_en),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .done(done), .state(state)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] ref_elem(input int w[4], input int x[4],
                                           input bit xp, input bit rl, input int e);
    int s = 0;
    int r = e / 2;
    int c = e % 2;
    logic [15:0] v;
    for (int k = 0; k < 2; k++)
      s += w[r*2+k] * (xp ? x[c*2+k] : x[k*2+c]);
    v = s[15:0];
    if (rl && v[15]) v = '0;
    return v;
  endfunction

  // behavioural reference: 0 load, 1 compute, 2 send, 3 ready
  int         ms = 0, tc = 0;
  int         inq[$];
  logic [7:0] oq[$];
  logic [15:0] mres[4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; tc = 0; inq.delete(); oq.delete();
    end else begin
      case (ms)
        0: if (in_valid) begin
          inq.push_back(int'($signed(in_data)));
          if (inq.size() == 8) begin
            int w[4], x[4];
            for (int k = 0; k < 4; k++) begin w[k] = inq[k]; x[k] = inq[k+4]; end
            for (int e = 0; e < 4; e++) mres[e] = ref_elem(w, x, xpose_en, relu_en, e);
            inq.delete(); ms = 1; tc = 0;
          end
        end
        1: if (tc == 3) ms = 3; else tc++;
        3: begin
          for (int e = 0; e < 4; e++) begin
            oq.push_back(mres[e][15:8]); oq.push_back(mres[e][7:0]);
          end
          ms = 2;
        end
        2: if (out_ready) begin
          void'(oq.pop_front());
          if (oq.size() == 0) ms = 0;
        end
        default: ms = 0;
      endcase
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(state == 2'(ms), "R4 state", state, ms);
    chk(in_ready == (ms == 0), "R2 in_ready", in_ready, ms == 0);
    chk(out_valid == (ms == 2), "R7 out_valid", out_valid, ms == 2);
    chk(done == (ms == 2 || ms == 3), "R10 done", done, ms == 2 || ms == 3);
    if (ms == 2 && out_valid) chk(out_data == oq[0], "R7 out_data", out_data, oq[0]);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WDOG) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic run_mm(input int w[4], input int x[4], input bit xp, input bit rl,
                        input bit gaps, input bit bp, input string tag);
    int i = 0, t = 0, n = 0;
    logic [7:0] got[8];
    while (i < 8) begin
      bit v;
      @(negedge clk);
      v = !(gaps && (t % 3 == 1));
      in_valid = v;
      in_data  = 8'((i < 4) ? w[i] : x[i-4]);
      xpose_en = xp; relu_en = rl;
      if (v && in_ready) i++;
      t++;
    end
    // R3 R5 R6: junk bytes and flipped modes during compute must not matter
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'h5A; xpose_en = !xp; relu_en = !rl;
    end
    t = 0;
    while (n < 8) begin
      bit r;
      @(negedge clk);
      in_valid = 1'b0;
      r = !(bp && (t % 3 == 2));
      out_ready = r;
      if (out_valid && r) begin got[n] = out_data; n++; end
      t++;
    end
    @(negedge clk);
    out_ready = 1'b0;
    // R9
    chk(state == 2'b00 && in_ready && !done, "R9 return", state, 0);
    for (int e = 0; e < 8; e++) begin
      logic [15:0] ev;
      logic [7:0]  eb;
      ev = ref_elem(w, x, xp, rl, e / 2);
      eb = (e % 2 == 0) ? ev[15:8] : ev[7:0];
      chk(got[e] == eb, tag, got[e], eb);
    end
  endtask

  initial begin
    int wi[4] = '{1, 0, 0, 1};
    int xa[4] = '{1, 2, 3, 4};
    int wb[4] = '{3, -2, 5, 7};
    int xb[4] = '{-4, 6, 1, -9};
    int wm[4] = '{-128, -128, -128, -128};
    int wc[4] = '{-7, 2, 9, -1};
    int xc[4] = '{4, -5, -3, 8};
    repeat (3) @(negedge clk);
    // R1
    chk(state == 2'b00 && !done && !out_valid && in_ready, "R1 reset", state, 0);
    rst_n = 1'b1;
    run_mm(wi, xa, 0, 0, 0, 0, "R2 identity");
    run_mm(wb, xb, 0, 0, 1, 0, "R3 gaps");
    run_mm(wb, xb, 0, 0, 0, 1, "R8 stall");
    run_mm(wb, xb, 1, 0, 1, 1, "R5 transpose");
    run_mm(wc, xc, 0, 1, 0, 0, "R6 relu");
    run_mm(wm, wm, 0, 0, 0, 0, "R4 wrap");
    run_mm(wm, wm, 0, 1, 0, 1, "R6 relu wrap");
    run_mm(wc, xc, 1, 1, 1, 1, "R5 transpose relu");
    for (int r = 0; r < 4; r++) begin
      int wr[4], xr[4];
      for (int k = 0; k < 4; k++) begin
        wr[k] = int'($signed(8'($urandom)));
        xr[k] = int'($signed(8'($urandom)));
      end
      run_mm(wr, xr, r[0], r[1], 1, 1, "R7 random");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule